// File: doc/BRIEF.md
# Missing-Tooth Gap Timer

This block watches the pulse train from a toothed wheel and raises a flag when a gap appears where one or more teeth should have been. It measures the time between valid tooth edges in units of a prescaled base clock. It divides that interval by a programmable multiplication factor to get a tick period, and it drives a 16-bit tooth counter with those ticks. Every valid tooth edge clears the counter. Because the tick rate follows the wheel speed, the counter reaches a given value after a fixed fraction of a tooth pitch, whatever the speed. A compare value set above one pitch's worth of ticks is therefore reached only when a tooth is missing.

The control path is a four-state machine. `ST_IDLE` holds everything cleared while `start` is low. `ST_WAIT_EDGE` waits for the first valid edge after start. `ST_MEASURE` times the first full interval, with the counter held. `ST_RUN` advances the counter on ticks.

The transitions are as follows. Start high takes IDLE to WAIT_EDGE. A valid edge takes WAIT_EDGE to MEASURE. A valid edge with reload enabled takes MEASURE to RUN. Start low takes any state to IDLE. Software sets the edge polarity, factor, prescale ratio, compare value and interrupt enable. It reads a sticky match flag with a clear input and a gated interrupt line.

Top module: `tooth_gap_timer`

## Requirements
- R1: `edge_sel` picks the valid tooth edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. Edges of a kind not selected have no effect.
- R2: `tooth_in` passes through a two-flop synchroniser. A change driven before clock edge k is acted on at clock edge k+2.
- R3: One base tick occurs every `prescale`+1 clocks while started. An interval is measured as the number of base ticks after the previous valid edge, up to and including the cycle of the current one.
- R4: The tick period is floor(interval / factor) base ticks, with a minimum of 1. A factor of 0 is treated as 1.
- R5: The period register loads at a valid edge in MEASURE or RUN only while `reload_en` is 1. Otherwise it keeps its previous value.
- R6: Every valid edge clears the tooth counter to 0. In RUN the counter then advances by one on each tick, so after a valid edge at clock e it holds N at clock e+N·P.
- R7: The match flag is set in the cycle the counter advances to `compare_val`, at most once per edge interval.
- R8: The tooth counter stops at 0xFFFF and does not wrap.
- R9: The counter does not advance before a period has been loaded after start.
- R10: While `start` is 0 the block returns to IDLE and no match can occur.
- R11: The match flag stays set until `flag_clr` is 1. A new match in the same cycle takes priority over the clear.
- R12: `irq` is the match flag gated by `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tooth_in | input | 1 | Raw tooth pulse from the wheel sensor |
| edge_sel | input | 2 | Valid edge selection |
| mult_factor | input | MULT_W | Ticks per measured interval |
| reload_en | input | 1 | Allows the period register to update |
| prescale | input | PSC_W | Base clock divide ratio minus one |
| compare_val | input | CNT_W | Counter value that signals a gap |
| irq_en | input | 1 | Interrupt enable |
| start | input | 1 | Runs the timer when 1 |
| flag_clr | input | 1 | Clears the match flag |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
A valid edge driven before clock k takes effect at edge k+2. The flag then appears at edge e+C·P, where e is that edge, C is the compare value and P is the period computed from the last two valid edges. The bench records e for every driven transition, then samples `match_flag` on the falling edge one cycle before that point, expecting it low, and at that point, expecting it high. With a prescale ratio of r, the phase of the first base tick is not known. The bench therefore checks the window from (C·P−1)·(r+1)+1 to C·P·(r+1) clocks after the edge. `irq` follows the flag in the same cycle, and a clear shows on the next sample.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_EDGE = 2'd1,
        ST_MEASURE   = 2'd2,
        ST_RUN       = 2'd3
    } tgt_state_e;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/tgt_edge_sync.sv
module tgt_edge_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);
    import tgt_pkg::*;

    logic [2:0] sync_q;
    logic       rise_w;
    logic       fall_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign rise_w = sync_q[1] & ~sync_q[2];
    assign fall_w = ~sync_q[1] & sync_q[2];

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: edge_hit = rise_w;
            EDGE_FALL: edge_hit = fall_w;
            EDGE_BOTH: edge_hit = rise_w | fall_w;
            default:   edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tgt_prescaler.sv
module tgt_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PSC_W-1:0] ratio,
    output logic             base_tick
);
    logic [PSC_W-1:0] div_q;

    assign base_tick = active && (div_q >= ratio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         div_q <= '0;
        else if (!active)   div_q <= '0;
        else if (base_tick) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // R3: between base ticks the divider only counts upward by one
    assert_div_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !base_tick) |=> (!active || div_q == $past(div_q) + 1'b1));
endmodule

// File: rtl/tgt_period_meas.sv
module tgt_period_meas #(
    parameter int CNT_W  = 16,
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              measuring,
    input  logic              edge_hit,
    input  logic              base_tick,
    input  logic              reload_en,
    input  logic [MULT_W-1:0] mult,
    output logic [CNT_W-1:0]  period,
    output logic              per_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]  span_q;
    logic [CNT_W-1:0]  span_now;
    logic [CNT_W-1:0]  divisor;
    logic [CNT_W-1:0]  quot;
    logic [CNT_W-1:0]  new_period;
    logic              load_w;

    assign span_now   = (base_tick && span_q != CNT_MAX) ? span_q + CNT_ONE : span_q;
    assign divisor    = (mult == '0) ? CNT_ONE : CNT_W'(mult);
    assign quot       = span_now / divisor;
    assign new_period = (quot == '0) ? CNT_ONE : quot;
    assign load_w     = edge_hit && measuring && reload_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q    <= '0;
            period    <= CNT_ONE;
            per_valid <= 1'b0;
        end else if (!active) begin
            span_q    <= '0;
            period    <= CNT_ONE;
            per_valid <= 1'b0;
        end else begin
            if (edge_hit)
                span_q <= '0;
            else if (measuring && base_tick && span_q != CNT_MAX)
                span_q <= span_q + CNT_ONE;
            if (load_w) begin
                period    <= new_period;
                per_valid <= 1'b1;
            end
        end
    end

    // R5: no reload enable, no period change
    assert_hold_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !reload_en) |=> $stable(period));
    // R4: a loaded period is never zero
    assert_period_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_valid |-> (period != '0));
endmodule

// File: rtl/tgt_tooth_ctrl.sv
module tgt_tooth_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 edge_hit,
    input  logic                 base_tick,
    input  logic                 reload_en,
    input  logic [CNT_W-1:0]     period,
    input  logic                 per_valid,
    input  logic [CNT_W-1:0]     compare_val,
    input  logic                 flag_clr,
    output tgt_pkg::tgt_state_e  state,
    output logic                 active,
    output logic                 measuring,
    output logic                 match_flag
);
    import tgt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tgt_state_e        state_nx;
    logic              running;
    logic [CNT_W-1:0]  tick_q;
    logic [CNT_W-1:0]  tooth_q;
    logic              tick_w;
    logic              match_w;
    logic              hit_seen_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!start) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_WAIT_EDGE;
                ST_WAIT_EDGE: if (edge_hit) state_nx = ST_MEASURE;
                ST_MEASURE:   if (edge_hit && reload_en) state_nx = ST_RUN;
                ST_RUN:       state_nx = ST_RUN;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state decode
    always_comb begin
        active    = 1'b1;
        measuring = 1'b0;
        running   = 1'b0;
        unique case (state)
            ST_IDLE:      active = 1'b0;
            ST_WAIT_EDGE: ;
            ST_MEASURE:   measuring = 1'b1;
            ST_RUN: begin
                measuring = 1'b1;
                running   = 1'b1;
            end
            default:      active = 1'b0;
        endcase
    end

    assign tick_w  = running && base_tick && (tick_q >= period - CNT_ONE);
    assign match_w = tick_w && !edge_hit && (tooth_q != CNT_MAX)
                     && ((tooth_q + CNT_ONE) == compare_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            tooth_q <= '0;
        end else if (!running || edge_hit) begin
            tick_q  <= '0;
            tooth_q <= '0;
        end else if (base_tick) begin
            tick_q <= tick_w ? '0 : tick_q + CNT_ONE;
            if (tick_w && tooth_q != CNT_MAX)
                tooth_q <= tooth_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (match_w)  match_flag <= 1'b1;
        else if (flag_clr) match_flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hit_seen_q <= 1'b0;
        else if (!running || edge_hit) hit_seen_q <= 1'b0;
        else if (match_w)             hit_seen_q <= 1'b1;
    end

    // R6: a valid edge while running restarts the count
    assert_edge_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && edge_hit) |=> (tooth_q == '0));
    // R8: the counter holds at its top value
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tooth_q == CNT_MAX && !edge_hit) |=> (tooth_q == CNT_MAX));
    // R9: running requires a period measured by the measurement unit
    assert_period_before_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> per_valid);
    // R10: start low forces idle
    assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (state == ST_IDLE));
    // R7: only one match per edge interval
    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_w |-> !hit_seen_q);
    // R7: match raises the flag
    assert_match_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_w |=> match_flag);
    // R11: clear without a match drops the flag
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !match_w) |=> !match_flag);
endmodule

// File: rtl/tooth_gap_timer.sv
module tooth_gap_timer #(
    parameter int CNT_W  = 16,
    parameter int MULT_W = 8,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tooth_in,
    input  logic [1:0]        edge_sel,
    input  logic [MULT_W-1:0] mult_factor,
    input  logic              reload_en,
    input  logic [PSC_W-1:0]  prescale,
    input  logic [CNT_W-1:0]  compare_val,
    input  logic              irq_en,
    input  logic              start,
    input  logic              flag_clr,
    output logic              match_flag,
    output logic              irq
);
    import tgt_pkg::*;

    tgt_state_e        state;
    logic              active;
    logic              measuring;
    logic              edge_hit;
    logic              base_tick;
    logic [CNT_W-1:0]  period;
    logic              per_valid;

    tgt_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (tooth_in),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    tgt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ratio     (prescale),
        .base_tick (base_tick)
    );

    tgt_period_meas #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .measuring (measuring),
        .edge_hit  (edge_hit),
        .base_tick (base_tick),
        .reload_en (reload_en),
        .mult      (mult_factor),
        .period    (period),
        .per_valid (per_valid)
    );

    tgt_tooth_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .edge_hit    (edge_hit),
        .base_tick   (base_tick),
        .reload_en   (reload_en),
        .period      (period),
        .per_valid   (per_valid),
        .compare_val (compare_val),
        .flag_clr    (flag_clr),
        .state       (state),
        .active      (active),
        .measuring   (measuring),
        .match_flag  (match_flag)
    );

    assign irq = match_flag & irq_en;

    // R12: interrupt only with its enable
    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_en);
endmodule

// File: tb/tooth_gap_timer_tb_top.sv
module tooth_gap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tooth_in = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic [7:0]  mult_factor = 8'd1;
    logic        reload_en = 1'b1;
    logic [7:0]  prescale = 8'd0;
    logic [15:0] compare_val = 16'd100;
    logic        irq_en = 1'b0;
    logic        start = 1'b0;
    logic        flag_clr = 1'b0;
    logic        match_flag;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int e_prev = 0;
    int e_last = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tooth_gap_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tooth_in(tooth_in), .edge_sel(edge_sel),
        .mult_factor(mult_factor), .reload_en(reload_en), .prescale(prescale),
        .compare_val(compare_val), .irq_en(irq_en), .start(start),
        .flag_clr(flag_clr), .match_flag(match_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic bit edge_ok(input logic v, input logic [1:0] sel);
        return v ? sel[0] : sel[1];
    endfunction

    function automatic int exp_period(input int d, input int m);
        int mm = (m == 0) ? 1 : m;
        int p = d / mm;
        return (p == 0) ? 1 : p;
    endfunction

    task automatic set_pin(input logic v);
        @(negedge clk);
        if (v != tooth_in && edge_ok(v, edge_sel)) begin
            e_prev = e_last;
            e_last = cyc + 3;
        end
        tooth_in = v;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wheel(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1);
            hold(hi - 1);
            set_pin(1'b0);
            hold(lo - 1);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] sel, input int m, input int c, input bit rl,
                           input int psc, input bit ie);
        @(negedge clk);
        start = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        edge_sel = sel;
        mult_factor = 8'(m);
        compare_val = 16'(c);
        reload_en = rl;
        prescale = 8'(psc);
        irq_en = ie;
        start = 1'b1;
        hold(2);
    endtask

    task automatic gap_check(input int p, input int c, input string req);
        int t = e_last + c * p;
        wait_to(t - 1);
        chk(match_flag == 1'b0, {req, " early"}, match_flag, 0);
        wait_to(t);
        chk(match_flag == 1'b1, {req, " on time"}, match_flag, 1);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(match_flag == 1'b0, "R11 clear", match_flag, 0);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        hold(3);
        rst_n = 1'b1;
        hold(2);
        chk(match_flag == 1'b0 && irq == 1'b0, "reset state", match_flag, 0);

        // R10: stopped timer ignores teeth
        start = 1'b0;
        compare_val = 16'd2;
        wheel(4, 5, 5);
        hold(100);
        chk(match_flag == 1'b0, "R10 stopped", match_flag, 0);

        // R9: no period loaded, no advance
        restart(2'b01, 1, 3, 1'b0, 0, 1'b0);
        wheel(4, 5, 5);
        hold(200);
        chk(match_flag == 1'b0, "R9 no period", match_flag, 0);

        // R1: no edge kind selected
        restart(2'b00, 1, 3, 1'b1, 0, 1'b0);
        wheel(4, 5, 5);
        hold(200);
        chk(match_flag == 1'b0, "R1 none selected", match_flag, 0);

        // R5: period frozen when reload disabled
        restart(2'b01, 2, 5, 1'b1, 0, 1'b0);
        wheel(3, 5, 5);
        @(negedge clk);
        reload_en = 1'b0;
        wheel(3, 10, 10);
        chk(match_flag == 1'b0, "R5 teeth present", match_flag, 0);
        gap_check(5, 5, "R5 R2 old period");
        pulse_clear();

        // R4: factor zero acts as one
        restart(2'b01, 0, 2, 1'b1, 0, 1'b0);
        wheel(3, 6, 6);
        gap_check(exp_period(e_last - e_prev, 0), 2, "R4 factor zero");
        pulse_clear();

        // R3: prescaled base clock
        restart(2'b01, 1, 2, 1'b1, 3, 1'b0);
        wheel(3, 8, 8);
        chk(match_flag == 1'b0, "R3 teeth present", match_flag, 0);
        wait_to(e_last + 28);
        chk(match_flag == 1'b0, "R3 early", match_flag, 0);
        wait_to(e_last + 32);
        chk(match_flag == 1'b1, "R3 window", match_flag, 1);

        // R12: interrupt gate
        chk(irq == 1'b0, "R12 gated off", irq, 0);
        @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R12 gated on", irq, 1);
        pulse_clear();
        chk(irq == 1'b0, "R12 follows clear", irq, 0);

        // R8: saturation, no second match
        restart(2'b01, 10, 12, 1'b1, 0, 1'b0);
        wheel(3, 5, 5);
        gap_check(1, 12, "R8 R7 first match");
        pulse_clear();
        hold(70000);
        chk(match_flag == 1'b0, "R8 no wrap rematch", match_flag, 0);

        // random mixes: R1 R2 R4 R6 R7 R11 R12
        for (int k = 0; k < 12; k++) begin
            int hi = 3 + int'($urandom_range(17));
            int lo = 3 + int'($urandom_range(17));
            int m = 1 + int'($urandom_range(7));
            logic [1:0] sel = 2'(1 + $urandom_range(2));
            bit ie = 1'($urandom_range(1));
            int p;
            restart(sel, m, 2 * m + 1, 1'b1, 0, ie);
            wheel(4, hi, lo);
            chk(match_flag == 1'b0, "R6 R1 teeth present", match_flag, 0);
            p = exp_period(e_last - e_prev, m);
            gap_check(p, 2 * m + 1, "R7 R2 R4 gap");
            chk(irq == ie, "R12 random", irq, int'(ie));
            pulse_clear();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule